// File: doc/BRIEF.md
# Six-Pin GPIO Port with Peripheral Pin Override

This block is a small general-purpose I/O port of six pins. Software reaches it over a simple register bus. Through that bus it sets each pin's direction, writes the value that output pins drive, and reads back pin state. Inputs from the pads pass through a two-flop synchronizer before any read path sees them.

On-chip serial peripherals can claim any pin without software's help. A pin whose transmit enable is high is driven as an output carrying the peripheral's transmit data. A pin whose receive enable is high is held as an input. In both cases the software direction bit is ignored. When both enables are high on one pin, transmit wins. Once a peripheral drops its enables, the software direction bit governs the pin again.

The register bus has a select, a write strobe, an 8-bit address, 8-bit write data and combinational 8-bit read data. There are three registers. Offset 0x10 is the output data register; reading it gives a mixed readback. Offset 0x11 is a read-only view of the synchronized pad levels. Offset 0x12 is the direction register.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset, the direction register and the output data register hold 0 and every pad_oe bit is 0.
- R2: Offset 0x12 is the direction register. It can be written and read at any time, bit n (n = 0..5) belongs to pin n, and read bits 7 and 6 are always 0.
- R3: With neither peripheral enable asserted on a pin, pad_oe for that pin equals its direction bit: 1 means output, 0 means input.
- R4: While periph_tx_en[n] is 1, pad_oe[n] is 1 and pad_out[n] equals periph_tx_data[n], whatever the direction bit holds.
- R5: While periph_rx_en[n] is 1 and periph_tx_en[n] is 0, pad_oe[n] is 0, whatever the direction bit holds.
- R6: When periph_tx_en[n] and periph_rx_en[n] are both 1, the transmit override wins and the pin is an output.
- R7: After both enables of a pin fall, pad_oe for that pin follows its direction bit again in the same cycle.
- R8: With periph_tx_en[n] at 0, pad_out[n] equals bit n of the output data register (offset 0x10). A write to that register updates pad_out at the next clock edge.
- R9: A read of offset 0x11 returns pad_in through a two-flop synchronizer, with bits 7 and 6 at 0. A pad change made between edges appears after the second rising edge and not after the first.
- R10: A read of offset 0x10 returns, per pin, the output data bit when the pin's effective direction is output, and the synchronized pad level when it is input.
- R11: Writes to offset 0x11 have no effect, and reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| periph_tx_en | input | 6 | Per-pin peripheral transmit enable |
| periph_tx_data | input | 6 | Per-pin peripheral transmit value |
| periph_rx_en | input | 6 | Per-pin peripheral receive enable |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables (1 = drive) |

## Verification
Two things can land in the same cycle: a peripheral override changing on a pin, and a software write to that pin's direction bit. The bench drives both in one clock. It judges pad_oe right after the edge against a direction computed arithmetically from transmit over receive over register. A full sweep of every transmit and receive enable pattern against several direction values covers the per-pin priority. A pad change timed between edges is sampled after one edge and after two, which checks the synchronizer lag.

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int NPINS    = 6,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter logic [AW-1:0] DATA_OFS = 'h10,
  parameter logic [AW-1:0] PIN_OFS  = 'h11,
  parameter logic [AW-1:0] DIR_OFS  = 'h12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] periph_tx_en,
  input  logic [NPINS-1:0] periph_tx_data,
  input  logic [NPINS-1:0] periph_rx_en,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam int PADW = DW - NPINS;

  logic [NPINS-1:0] dir_q, out_q, sync1_q, sync2_q, eff_dir, mixed;
  logic [1:0]       age_q;
  logic             wr_dir, wr_out;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:NPINS];
  assign wr_dir = bus_sel && bus_wr && (bus_addr == DIR_OFS);
  assign wr_out = bus_sel && bus_wr && (bus_addr == DATA_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata[NPINS-1:0];
      if (wr_out) out_q <= bus_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      age_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign eff_dir[i] = periph_tx_en[i] | (~periph_rx_en[i] & dir_q[i]);
    assign pad_out[i] = periph_tx_en[i] ? periph_tx_data[i] : out_q[i];
    assign mixed[i]   = eff_dir[i] ? out_q[i] : sync2_q[i];
  end
  assign pad_oe = eff_dir;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        DATA_OFS: bus_rdata = {{PADW{1'b0}}, mixed};
        PIN_OFS:  bus_rdata = {{PADW{1'b0}}, sync2_q};
        DIR_OFS:  bus_rdata = {{PADW{1'b0}}, dir_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_dir_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == DIR_OFS) |-> bus_rdata[DW-1:NPINS] == '0);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata[NPINS-1:0]));

  p_tx_forces_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_tx_en & ~pad_oe) == '0) && (((pad_out ^ periph_tx_data) & periph_tx_en) == '0));

  p_rx_forces_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_rx_en & ~periph_tx_en & pad_oe) == '0);

  p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> sync2_q == $past(pad_in, 2));

  p_pin_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == PIN_OFS) |=> $stable(dir_q) && $stable(out_q));
endmodule

// File: tb/gpio_port_ovr_tb_top.sv
module gpio_port_ovr_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [5:0] tx_en = 0, tx_d = 0, rx_en = 0, pad_in = 0, pad_out, pad_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_ovr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_tx_en(tx_en), .periph_tx_data(tx_d), .periph_rx_en(rx_en),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [5:0] dv;
    #22 rst_n = 1;
    @(negedge clk);
    chk("R1 oe", {2'b0, pad_oe}, 8'h00);
    chk("R1 out", {2'b0, pad_out}, 8'h00);
    rd(8'h12, r); chk("R1 dir", r, 8'h00);

    wr(8'h12, 8'hFF); rd(8'h12, r); chk("R2 dir hi zero", r, 8'h3F);
    wr(8'h12, 8'h15); rd(8'h12, r); chk("R2 dir rw", r, 8'h15);
    chk("R3 oe follows dir", {2'b0, pad_oe}, 8'h15);

    wr(8'h10, 8'h2A); chk("R8 pad_out", {2'b0, pad_out}, 8'h2A);

    // R4 R5 R6 exhaustive priority sweep
    for (int d = 0; d < 4; d++) begin
      dv = (d == 0) ? 6'h00 : (d == 1) ? 6'h3F : (d == 2) ? 6'h15 : 6'h2A;
      wr(8'h12, {2'b0, dv});
      for (int t = 0; t < 64; t++)
        for (int x = 0; x < 64; x++) begin
          @(negedge clk);
          tx_en = t[5:0]; rx_en = x[5:0]; tx_d = ~t[5:0] ^ x[5:0];
          #1;
          chk("R4 R5 R6 oe", {2'b0, pad_oe}, {2'b0, t[5:0] | (~x[5:0] & dv)});
          chk("R4 R8 out", {2'b0, pad_out},
              {2'b0, (t[5:0] & (~t[5:0] ^ x[5:0])) | (~t[5:0] & 6'h2A)});
        end
    end

    // R7 release with simultaneous direction write
    @(negedge clk);
    tx_en = 6'h3F; rx_en = 6'h00;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h12; bus_wdata = 8'h09;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R4 oe during write", {2'b0, pad_oe}, 8'h3F);
    tx_en = 6'h00; rx_en = 6'h00;
    #1 chk("R7 release", {2'b0, pad_oe}, 8'h09);
    rx_en = 6'h3F; #1 chk("R5 rx over dir", {2'b0, pad_oe}, 8'h00);
    rx_en = 6'h00; #1 chk("R7 rx release", {2'b0, pad_oe}, 8'h09);

    // R9 synchronizer lag
    @(negedge clk); pad_in = 6'h35;
    rd(8'h11, r); chk("R9 one edge", r, 8'h00);
    rd(8'h11, r); chk("R9 two edges", r, 8'h35);

    // R10 mixed readback
    wr(8'h12, 8'h0F);
    rd(8'h10, r); chk("R10 mixed", r, 8'h3A);
    tx_en = 6'h30; rd(8'h10, r); chk("R10 tx eff out", r, 8'h2A);
    tx_en = 6'h00; rx_en = 6'h0F; rd(8'h10, r); chk("R10 rx eff in", r, 8'h35);
    rx_en = 6'h00;

    // R11
    wr(8'h11, 8'hFF);
    rd(8'h11, r); chk("R11 pin ro", r, 8'h35);
    rd(8'h12, r); chk("R11 dir untouched", r, 8'h0F);
    rd(8'h10, r); chk("R11 out untouched", r, 8'h3A);
    rd(8'h05, r); chk("R11 unmapped", r, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule